// File: doc/BRIEF.md
# Multiplexed DRAM Address Generator

This block turns a byte address on a 64-bit memory bus into the signals a pair of 32-bit DRAM modules needs. The two modules sit side by side and together form one 64-bit bank. The block decodes which bank the address falls in and then splits the address into a row number and a column number. It presents these two numbers one after the other on a shared 12-bit address bus, with RAS and CAS strobes, and it drives an 8-bit byte-enable vector for the data bus.

Each bank has its own row/column geometry, picked at run time from a fixed set of eight codes. Row or column bits that lie above the configured geometry are forced to zero, so a small module sees higher addresses fold back onto its own cells. The largest code drives all twelve row bits and all twelve column bits. This lets firmware size the memory by writing near the top of a bank and searching upward for the place where the data reappears.

A request whose bank field names a bank that does not exist or is not populated is refused. The block raises an error pulse and drives no strobes for it. Refresh, timing calibration, parity and the data path are handled elsewhere.

Top module: `dram_addr_mux`

## Requirements
- R1: The 32-bit request address is split as bank field [31:27], row field [26:15], column field [14:3] and byte lane [2:0].
- R2: Geometry codes give rows×columns of 0:9×9, 1:10×9, 2:10×10, 3:11×10, 4:11×11, 5:12×10, 6:12×11, 7:12×12. Row and column bits at or above the configured count are driven as zero, so higher addresses alias. Each bank uses its own code, held in cfg_geom[3*b+2:3*b].
- R3: Code 7 drives all 12 row bits and all 12 column bits unmasked. For example, 0x07DFFFF8 gives row 0xFBF and column 0xFFF.
- R4: The request is accepted at a rising edge while req_valid and req_ready are both high. From the next cycle, ras is high with the row on dram_addr for PHASE_CYC cycles. Then ras and cas are both high with the column for PHASE_CYC cycles. The address stays steady within each phase.
- R5: In the cycle after the column phase, ras, cas and dram_addr return to zero and done is high for exactly one cycle. req_ready is high only while no access is in progress.
- R6: The byte-enable vector has bit i for byte lane i. req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The run of 2^size enabled lanes starts at the byte lane rounded down to a multiple of 2^size, and it holds for the whole access.
- R7: If an accepted request has a bank field of NUM_BANKS or more, or targets a bank whose cfg_present bit is clear, err is high for one cycle in the next cycle. No ras or cas is issued and req_ready stays high.
- R8: During an access, bank_sel is one-hot with bit b set for bank b. It is zero when idle.
- R9: After reset, ras, cas, done, err, bank_sel, byte_en and dram_addr are zero and req_ready is high.
- R10: A request presented while req_ready is low is ignored. It does not change the address of the access in progress and raises no err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | Access size code (log2 of the byte count) |
| req_ready | output | 1 | High when a request can be accepted |
| cfg_present | input | 2 | One bit per bank: bank populated |
| cfg_geom | input | 6 | Geometry code per bank, 3 bits each |
| dram_addr | output | 12 | Multiplexed row/column address |
| ras | output | 1 | Row strobe, active high |
| cas | output | 1 | Column strobe, active high |
| bank_sel | output | 2 | One-hot bank select during an access |
| byte_en | output | 8 | Byte-lane enables for the 64-bit data bus |
| done | output | 1 | One-cycle pulse when an access completes |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong geometry decode or mask shows up on dram_addr in the first cycle of the row or column phase. It appears as a nonzero bit above the configured width, or as a missing bit below it. A phase counter that is off by one moves the rise of cas, or the done pulse, by one cycle away from the PHASE_CYC count. A sequencer stuck in a busy state leaves req_ready low, and the next request never gets its strobes. A bad bank check either pulses err while ras rises, or issues strobes where only err was due. Every one of these faults is visible within 2·PHASE_CYC+1 cycles of the request being accepted.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  localparam int GEOM_W  = 3;
  localparam int NBITS_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2
  } seq_state_t;

  function automatic logic [NBITS_W-1:0] geom_rows(input logic [GEOM_W-1:0] code);
    case (code)
      3'd0:          geom_rows = 4'd9;
      3'd1, 3'd2:    geom_rows = 4'd10;
      3'd3, 3'd4:    geom_rows = 4'd11;
      default:       geom_rows = 4'd12;
    endcase
  endfunction

  function automatic logic [NBITS_W-1:0] geom_cols(input logic [GEOM_W-1:0] code);
    case (code)
      3'd0, 3'd1:    geom_cols = 4'd9;
      3'd2, 3'd3:    geom_cols = 4'd10;
      3'd5:          geom_cols = 4'd10;
      3'd4, 3'd6:    geom_cols = 4'd11;
      default:       geom_cols = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/dram_geom_mask.sv
module dram_geom_mask
  import dram_mux_pkg::*;
#(
  parameter int MUX_W = 12
) (
  input  logic [GEOM_W-1:0] geom,
  output logic [MUX_W-1:0]  row_mask,
  output logic [MUX_W-1:0]  col_mask
);
  logic [NBITS_W-1:0] n_rows;
  logic [NBITS_W-1:0] n_cols;

  assign n_rows = geom_rows(geom);
  assign n_cols = geom_cols(geom);

  for (genvar g = 0; g < MUX_W; g++) begin : g_bit
    assign row_mask[g] = (NBITS_W'(g) < n_rows);
    assign col_mask[g] = (NBITS_W'(g) < n_cols);
  end
endmodule

// File: rtl/dram_lane_enable.sv
module dram_lane_enable #(
  parameter int LANE_W = 3,
  parameter int SIZE_W = 2,
  localparam int BE_W  = 1 << LANE_W
) (
  input  logic [LANE_W-1:0] lane,
  input  logic [SIZE_W-1:0] size,
  output logic [BE_W-1:0]   be
);
  logic [LANE_W:0]   span;
  logic [LANE_W-1:0] base;
  logic [LANE_W:0]   stop;

  assign span = (LANE_W+1)'(1) << size;
  assign base = lane & ~(span[LANE_W-1:0] - LANE_W'(1));
  assign stop = {1'b0, base} + span;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign be[g] = ({1'b0, base} <= (LANE_W+1)'(g)) && ((LANE_W+1)'(g) < stop);
  end
endmodule

// File: rtl/dram_field_split.sv
module dram_field_split #(
  parameter int BASE_W    = 5,
  parameter int MUX_W     = 12,
  parameter int LANE_W    = 3,
  parameter int SIZE_W    = 2,
  parameter int NUM_BANKS = 2,
  localparam int ADDR_W   = BASE_W + 2*MUX_W + LANE_W,
  localparam int BE_W     = 1 << LANE_W,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [SIZE_W-1:0]          size,
  input  logic [NUM_BANKS-1:0]       present,
  input  logic [NUM_BANKS*MUX_W-1:0] row_masks,
  input  logic [NUM_BANKS*MUX_W-1:0] col_masks,
  output logic [MUX_W-1:0]           row_out,
  output logic [MUX_W-1:0]           col_out,
  output logic [BE_W-1:0]            be_out,
  output logic [NUM_BANKS-1:0]       sel_out,
  output logic                       bank_bad
);
  logic [BASE_W-1:0] bank_fld;
  logic [MUX_W-1:0]  row_fld;
  logic [MUX_W-1:0]  col_fld;
  logic [LANE_W-1:0] lane_fld;
  logic [BSEL_W-1:0] bidx;
  logic              in_range;

  assign bank_fld = addr[ADDR_W-1 -: BASE_W];
  assign row_fld  = addr[LANE_W+MUX_W +: MUX_W];
  assign col_fld  = addr[LANE_W +: MUX_W];
  assign lane_fld = addr[LANE_W-1:0];
  assign bidx     = bank_fld[BSEL_W-1:0];

  assign in_range = (bank_fld < BASE_W'(NUM_BANKS));
  assign bank_bad = !in_range || !present[bidx];

  assign row_out = row_fld & row_masks[bidx*MUX_W +: MUX_W];
  assign col_out = col_fld & col_masks[bidx*MUX_W +: MUX_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel_out[b] = (bidx == BSEL_W'(b));
  end

  dram_lane_enable #(
    .LANE_W (LANE_W),
    .SIZE_W (SIZE_W)
  ) u_lane (
    .lane (lane_fld),
    .size (size),
    .be   (be_out)
  );
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_mux_pkg::*;
#(
  parameter int MUX_W     = 12,
  parameter int BE_W      = 8,
  parameter int NUM_BANKS = 2,
  parameter int PHASE_CYC = 2,
  localparam int CNT_W    = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic                 go_err,
  input  logic [MUX_W-1:0]     row_in,
  input  logic [MUX_W-1:0]     col_in,
  input  logic [BE_W-1:0]      be_in,
  input  logic [NUM_BANKS-1:0] sel_in,
  output logic                 idle,
  output logic [MUX_W-1:0]     addr_q,
  output logic                 ras_q,
  output logic                 cas_q,
  output logic [BE_W-1:0]      be_q,
  output logic [NUM_BANKS-1:0] sel_q,
  output logic                 done_q,
  output logic                 err_q
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [MUX_W-1:0] col_hold;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      col_hold <= '0;
      addr_q   <= '0;
      ras_q    <= 1'b0;
      cas_q    <= 1'b0;
      be_q     <= '0;
      sel_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            state    <= ST_ROW;
            cnt      <= CNT_LAST;
            addr_q   <= row_in;
            col_hold <= col_in;
            ras_q    <= 1'b1;
            be_q     <= be_in;
            sel_q    <= sel_in;
          end else if (go_err) begin
            err_q <= 1'b1;
          end
        end
        ST_ROW: begin
          if (cnt == '0) begin
            state  <= ST_COL;
            cnt    <= CNT_LAST;
            addr_q <= col_hold;
            cas_q  <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_COL: begin
          if (cnt == '0) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            ras_q  <= 1'b0;
            cas_q  <= 1'b0;
            be_q   <= '0;
            sel_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_mux_pkg::*;
#(
  parameter int BASE_W    = 5,
  parameter int MUX_W     = 12,
  parameter int LANE_W    = 3,
  parameter int SIZE_W    = 2,
  parameter int NUM_BANKS = 2,
  parameter int PHASE_CYC = 2,
  localparam int ADDR_W   = BASE_W + 2*MUX_W + LANE_W,
  localparam int BE_W     = 1 << LANE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [SIZE_W-1:0]           req_size,
  output logic                        req_ready,
  input  logic [NUM_BANKS-1:0]        cfg_present,
  input  logic [NUM_BANKS*GEOM_W-1:0] cfg_geom,
  output logic [MUX_W-1:0]            dram_addr,
  output logic                        ras,
  output logic                        cas,
  output logic [NUM_BANKS-1:0]        bank_sel,
  output logic [BE_W-1:0]             byte_en,
  output logic                        done,
  output logic                        err
);
  logic [NUM_BANKS*MUX_W-1:0] row_masks;
  logic [NUM_BANKS*MUX_W-1:0] col_masks;
  logic [MUX_W-1:0]           row_m;
  logic [MUX_W-1:0]           col_m;
  logic [BE_W-1:0]            be_c;
  logic [NUM_BANKS-1:0]       sel_c;
  logic                       bank_bad;
  logic                       idle;
  logic                       accept;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dram_geom_mask #(.MUX_W(MUX_W)) u_mask (
      .geom     (cfg_geom[b*GEOM_W +: GEOM_W]),
      .row_mask (row_masks[b*MUX_W +: MUX_W]),
      .col_mask (col_masks[b*MUX_W +: MUX_W])
    );
  end

  dram_field_split #(
    .BASE_W    (BASE_W),
    .MUX_W     (MUX_W),
    .LANE_W    (LANE_W),
    .SIZE_W    (SIZE_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_split (
    .addr      (req_addr),
    .size      (req_size),
    .present   (cfg_present),
    .row_masks (row_masks),
    .col_masks (col_masks),
    .row_out   (row_m),
    .col_out   (col_m),
    .be_out    (be_c),
    .sel_out   (sel_c),
    .bank_bad  (bank_bad)
  );

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  dram_strobe_seq #(
    .MUX_W     (MUX_W),
    .BE_W      (BE_W),
    .NUM_BANKS (NUM_BANKS),
    .PHASE_CYC (PHASE_CYC)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .go     (accept && !bank_bad),
    .go_err (accept && bank_bad),
    .row_in (row_m),
    .col_in (col_m),
    .be_in  (be_c),
    .sel_in (sel_c),
    .idle   (idle),
    .addr_q (dram_addr),
    .ras_q  (ras),
    .cas_q  (cas),
    .be_q   (byte_en),
    .sel_q  (bank_sel),
    .done_q (done),
    .err_q  (err)
  );
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk
  import dram_mux_pkg::*;
#(
  parameter int MUX_W     = 12,
  parameter int BE_W      = 8,
  parameter int NUM_BANKS = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_ready,
  input logic [NUM_BANKS*GEOM_W-1:0] cfg_geom,
  input logic [MUX_W-1:0]            dram_addr,
  input logic                        ras,
  input logic                        cas,
  input logic [NUM_BANKS-1:0]        bank_sel,
  input logic [BE_W-1:0]             byte_en,
  input logic                        done,
  input logic                        err
);
  logic [GEOM_W-1:0]  act_geom;
  logic [NBITS_W-1:0] nr;
  logic [NBITS_W-1:0] nc;
  logic [MUX_W-1:0]   rmask;
  logic [MUX_W-1:0]   cmask;

  always_comb begin
    act_geom = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) act_geom = cfg_geom[b*GEOM_W +: GEOM_W];
    end
  end

  assign nr = geom_rows(act_geom);
  assign nc = geom_cols(act_geom);

  for (genvar g = 0; g < MUX_W; g++) begin : g_m
    assign rmask[g] = (NBITS_W'(g) < nr);
    assign cmask[g] = (NBITS_W'(g) < nc);
  end

  a_r4_cas_needs_ras: assert property (@(posedge clk) disable iff (rst)
    cas |-> ras);
  a_r4_row_before_col: assert property (@(posedge clk) disable iff (rst)
    $rose(cas) |-> ($past(ras) && !$past(cas)));
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (ras && $past(ras) && (cas == $past(cas))) |-> $stable(dram_addr));
  a_r2_row_in_geom: assert property (@(posedge clk) disable iff (rst)
    (ras && !cas) |-> ((dram_addr & ~rmask) == '0));
  a_r2_col_in_geom: assert property (@(posedge clk) disable iff (rst)
    cas |-> ((dram_addr & ~cmask) == '0));
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    ras |-> ($countones(bank_sel) == 1));
  a_r8_sel_idle: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_sel));
  a_r7_err_no_strobe: assert property (@(posedge clk) disable iff (rst)
    err |-> (!ras && !cas && req_ready));
  a_r5_done_after_col: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cas) && !ras));
  a_r6_be_live: assert property (@(posedge clk) disable iff (rst)
    ras |-> (byte_en != '0));
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    ras |-> !req_ready);
endmodule

bind dram_addr_mux dram_addr_mux_chk #(
  .MUX_W     (MUX_W),
  .BE_W      (BE_W),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .cfg_geom  (cfg_geom),
  .dram_addr (dram_addr),
  .ras       (ras),
  .cas       (cas),
  .bank_sel  (bank_sel),
  .byte_en   (byte_en),
  .done      (done),
  .err       (err)
);

// File: tb/dram_addr_mux_tb.sv
module dram_addr_mux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE_CYC  = 2;
  localparam int NVEC       = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready;
  logic [1:0]  cfg_present = 2'b11;
  logic [5:0]  cfg_geom = '0;
  logic [11:0] dram_addr;
  logic        ras, cas, done, err;
  logic [1:0]  bank_sel;
  logic [7:0]  byte_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_addr_mux #(.PHASE_CYC(PHASE_CYC)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_ready(req_ready), .cfg_present(cfg_present),
    .cfg_geom(cfg_geom), .dram_addr(dram_addr), .ras(ras), .cas(cas),
    .bank_sel(bank_sel), .byte_en(byte_en), .done(done), .err(err)
  );

  // {addr, size, geom, row, col, be, sel, err}
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h07FFFFF8, 2'd3, 3'd0, 12'h1FF, 12'h1FF, 8'hFF, 2'b01, 1'b0},
    {32'h07FFFFF8, 2'd3, 3'd7, 12'hFFF, 12'hFFF, 8'hFF, 2'b01, 1'b0},
    {32'h07DFFFF8, 2'd3, 3'd7, 12'hFBF, 12'hFFF, 8'hFF, 2'b01, 1'b0},
    {32'h0891A2B5, 2'd0, 3'd3, 12'h123, 12'h056, 8'h20, 2'b10, 1'b0},
    {32'h055E6F7E, 2'd1, 3'd5, 12'hABC, 12'h1EF, 8'hC0, 2'b01, 1'b0},
    {32'h0D5E6F7E, 2'd2, 3'd1, 12'h2BC, 12'h1EF, 8'hF0, 2'b10, 1'b0},
    {32'h07FFFFF8, 2'd2, 3'd4, 12'h7FF, 12'h7FF, 8'h0F, 2'b01, 1'b0},
    {32'h0FFFFFFB, 2'd1, 3'd6, 12'hFFF, 12'h7FF, 8'h0C, 2'b10, 1'b0},
    {32'h10000000, 2'd3, 3'd7, 12'h000, 12'h000, 8'h00, 2'b00, 1'b1},
    {32'hF8000000, 2'd3, 3'd7, 12'h000, 12'h000, 8'h00, 2'b00, 1'b1},
    {32'h00000000, 2'd3, 3'd2, 12'h000, 12'h000, 8'hFF, 2'b01, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drives one request and checks the full strobe sequence (R1..R8).
  task automatic run_access(input logic [31:0] a, input logic [1:0] sz,
                            input logic [11:0] er, input logic [11:0] ec,
                            input logic [7:0] ebe, input logic [1:0] esel,
                            input logic eerr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    if (eerr) begin
      check("R7 err pulse", {31'd0, err}, 32'd1);
      check("R7 no ras", {31'd0, ras}, 32'd0);
      check("R7 ready kept", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      check("R7 err one cycle", {31'd0, err}, 32'd0);
      return;
    end
    for (int p = 0; p < PHASE_CYC; p++) begin
      check("R4 row ras", {30'd0, ras, cas}, 32'd2);
      check("R1 R2 row addr", {20'd0, dram_addr}, {20'd0, er});
      check("R6 byte_en", {24'd0, byte_en}, {24'd0, ebe});
      check("R8 bank_sel", {30'd0, bank_sel}, {30'd0, esel});
      check("R5 busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    for (int p = 0; p < PHASE_CYC; p++) begin
      check("R4 col cas", {30'd0, ras, cas}, 32'd3);
      check("R1 R2 col addr", {20'd0, dram_addr}, {20'd0, ec});
      check("R6 byte_en held", {24'd0, byte_en}, {24'd0, ebe});
      @(negedge clk);
    end
    check("R5 done", {31'd0, done}, 32'd1);
    check("R5 strobes off", {30'd0, ras, cas}, 32'd0);
    check("R5 addr zero", {20'd0, dram_addr}, 32'd0);
    check("R5 ready", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 ras/cas", {30'd0, ras, cas}, 32'd0);
    check("R9 done/err", {30'd0, done, err}, 32'd0);
    check("R9 addr", {20'd0, dram_addr}, 32'd0);
    check("R9 sel/be", {22'd0, bank_sel, byte_en}, 32'd0);
    check("R9 ready", {31'd0, req_ready}, 32'd1);

    // Table walk: target bank gets the vector geometry, other bank the complement (R2 per bank, R3)
    for (int i = 0; i < NVEC; i++) begin
      logic [71:0] v;
      v = VEC[i];
      cfg_present = 2'b11;
      if (v[71:67] == 5'd1) cfg_geom = {v[37:35], ~v[37:35]};
      else                  cfg_geom = {~v[37:35], v[37:35]};
      run_access(v[71:40], v[39:38], v[34:23], v[22:11], v[10:3], v[2:1], v[0]);
    end

    // R7: bank 1 not populated
    cfg_present = 2'b01;
    run_access(32'h08000000, 2'd3, 12'h0, 12'h0, 8'h0, 2'b00, 1'b1);
    cfg_present = 2'b11;

    // R10: request held during busy is ignored
    cfg_geom = 6'o77;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h00012348; req_size = 2'd3;
    @(negedge clk);
    req_addr = 32'h10000000;
    for (int p = 0; p < 2*PHASE_CYC; p++) begin
      check("R10 no err while busy", {31'd0, err}, 32'd0);
      if (p >= PHASE_CYC)
        check("R10 col unchanged", {20'd0, dram_addr}, 32'h469);
      @(negedge clk);
    end
    check("R10 done", {31'd0, done}, 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 no late err", {31'd0, err}, 32'd0);
    check("R10 idle", {30'd0, ras, cas}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule